// File: doc/BRIEF.md
# Segmented Overlap-Add FIR Filter

This block applies a finite impulse response to an unbroken stream of signed samples. It does not run a delay line on every sample. It gathers the stream into fixed, back-to-back segments of `SEG_LEN` samples and convolves each segment with the `TAPS` coefficients by itself. A full convolution of one segment yields `SEG_LEN + TAPS - 1` values. The first `SEG_LEN` values are sent out. The final `TAPS - 1` values are stored at full precision and added to the head of the next segment's result. Because of this carry-over, the joined output is the same as filtering the whole stream in one pass.

Samples enter through a valid/ready handshake. `in_ready` stays high while a segment is being gathered and drops while that segment is being convolved. Coefficients are written one tap per cycle through a simple write port. Results leave as single-cycle `out_valid` pulses. Each result is computed with a full-width accumulator and then clipped to the signed output width. A single multiply-accumulate unit handles one tap per cycle. A segment therefore takes `SEG_LEN` load cycles plus `(SEG_LEN + TAPS - 1) * TAPS` compute cycles.

Top module: `ola_fir_top`

## Requirements
- R1: The block accepts exactly `SEG_LEN` samples per segment (one per cycle in which `in_valid` and `in_ready` are both high). After the last sample of a segment is accepted, `in_ready` is low in the next cycle and stays low until that segment is fully processed.
- R2: Each segment produces exactly `SEG_LEN` output pulses on `out_valid`. `out_valid` is never high in a cycle where `in_ready` is high.
- R3: Output number `i` of a stream equals the clipped value of the sum over `k` of `h[k] * x[i-k]`, where terms with `i-k < 0` are zero. This holds for every `i`, so the result matches a direct convolution of the whole stream.
- R4: The last `TAPS-1` partial sums of a segment are kept at full precision and added to the first `TAPS-1` outputs of the next segment.
- R5: The stored carry-over starts at zero, and a synchronous `rst` clears it again. After reset, the first `TAPS-1` outputs depend only on samples accepted after that reset.
- R6: Results outside the signed `OUT_W` range are clipped to `2^(OUT_W-1)-1` or `-2^(OUT_W-1)`. Accumulation before the clip is exact.
- R7: Writing `coef_data` with `coef_we` high stores it as tap `coef_addr`. Tap 0 multiplies the newest sample and tap `k` multiplies the sample `k` positions earlier. A synchronous `rst` clears all taps to zero.
- R8: In the cycle after a cycle with `rst` high, `out_valid` is 0 and `in_ready` is 1.
- R9: `in_valid` while `in_ready` is low has no effect. No sample is taken, and the segment position is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block is gathering a segment and will take the sample |
| in_data | input | DATA_W | Signed input sample |
| coef_we | input | 1 | Write strobe for one coefficient |
| coef_addr | input | $clog2(TAPS) | Tap index being written |
| coef_data | input | COEF_W | Signed coefficient value |
| out_valid | output | 1 | One filtered sample present on out_data |
| out_data | output | OUT_W | Signed, clipped filtered sample |

## Verification
The bench goes after segment boundaries. An impulse placed just before a boundary has a response that must be split across two segments. A design that drops or misplaces the stored tail shows a gap or a doubled value in the first `TAPS-1` outputs of the next segment. Reset is applied after a stream that leaves a nonzero tail, so a design that keeps stale state corrupts the head of the following stream. Full-scale inputs and coefficients drive the sums far past the output range, which catches wrap-around in place of clipping. `in_valid` is held high with a junk value while the block computes, so a design that takes samples out of turn shifts all later results and starts its next segment early.

// File: rtl/ola_pkg.sv
package ola_pkg;

  typedef enum logic {
    ST_LOAD = 1'b0,
    ST_CONV = 1'b1
  } ola_state_e;

  // Accumulator width that holds a full convolution sum without loss,
  // plus one guard bit for adding the carried tail.
  function automatic int ola_acc_bits(input int dw, input int cw, input int taps);
    return dw + cw + $clog2(taps) + 1;
  endfunction

endpackage

// File: rtl/ola_sample_buf.sv
module ola_sample_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic signed [DW-1:0] wdata,
  input  logic [AW-1:0]        raddr,
  output logic signed [DW-1:0] rdata
);

  logic signed [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/ola_coef_bank.sv
module ola_coef_bank #(
  parameter int CW   = 16,
  parameter int TAPS = 8,
  localparam int KW  = $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [KW-1:0]        waddr,
  input  logic signed [CW-1:0] wdata,
  input  logic [KW-1:0]        raddr,
  output logic signed [CW-1:0] rdata
);

  logic signed [CW-1:0] tap_q [TAPS];

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst)                            tap_q[t] <= '0;
      else if (we && waddr == KW'(t))     tap_q[t] <= wdata;
    end
  end

  assign rdata = tap_q[raddr];

endmodule

// File: rtl/ola_tail_store.sv
module ola_tail_store #(
  parameter int ACCW  = 32,
  parameter int DEPTH = 7,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic signed [ACCW-1:0] wdata,
  input  logic [AW-1:0]          raddr,
  output logic signed [ACCW-1:0] rdata
);

  logic signed [ACCW-1:0] tail_q [DEPTH];

  for (genvar t = 0; t < DEPTH; t++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                          tail_q[t] <= '0;
      else if (we && waddr == AW'(t))   tail_q[t] <= wdata;
    end
  end

  assign rdata = tail_q[raddr];

endmodule

// File: rtl/ola_mac.sv
module ola_mac #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int ACCW = 36
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step,
  input  logic                   restart,
  input  logic signed [DW-1:0]   x,
  input  logic signed [CW-1:0]   h,
  output logic signed [ACCW-1:0] acc_q,
  output logic signed [ACCW-1:0] sum_d
);

  function automatic logic signed [ACCW-1:0] mul_ext(
    input logic signed [DW-1:0] a,
    input logic signed [CW-1:0] b
  );
    logic signed [ACCW-1:0] ea;
    logic signed [ACCW-1:0] eb;
    ea = ACCW'(a);
    eb = ACCW'(b);
    return ea * eb;
  endfunction

  assign sum_d = acc_q + mul_ext(x, h);

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (step) acc_q <= restart ? '0 : sum_d;
  end

endmodule

// File: rtl/ola_fir_top.sv
module ola_fir_top
  import ola_pkg::*;
#(
  parameter int SEG_LEN = 64,
  parameter int TAPS    = 8,
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int OUT_W   = 16,
  localparam int KW     = $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic                     coef_we,
  input  logic [KW-1:0]            coef_addr,
  input  logic signed [COEF_W-1:0] coef_data,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_data
);

  localparam int ACCW   = ola_acc_bits(DATA_W, COEF_W, TAPS);
  localparam int AW     = $clog2(SEG_LEN);
  localparam int LAST_N = SEG_LEN + TAPS - 2;
  localparam int NW     = $clog2(LAST_N + 1);
  localparam int TDEPTH = TAPS - 1;
  localparam int TAW    = (TDEPTH > 1) ? $clog2(TDEPTH) : 1;

  localparam logic signed [ACCW-1:0] OMAX = ACCW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [ACCW-1:0] OMIN = -OMAX - ACCW'(1);

  function automatic logic signed [OUT_W-1:0] clip(input logic signed [ACCW-1:0] v);
    if (v > OMAX)      return OUT_W'(OMAX);
    else if (v < OMIN) return OUT_W'(OMIN);
    else               return OUT_W'(v);
  endfunction

  ola_state_e       state_q;
  logic [AW-1:0]    wr_idx_q;
  logic [NW-1:0]    n_q;
  logic [KW-1:0]    k_q;

  // Named internal events, also observed by the bound checker.
  logic accept;
  logic seg_full;
  logic tap_last;
  logic emit;
  logic tail_wr;
  logic seg_done;

  logic [NW:0]              diff_u;
  logic                     in_seg;
  logic signed [DATA_W-1:0] x_rd;
  logic signed [DATA_W-1:0] x_eff;
  logic signed [COEF_W-1:0] h_rd;
  logic signed [ACCW-1:0]   acc_q;
  logic signed [ACCW-1:0]   sum_d;
  logic signed [ACCW-1:0]   tail_rd;
  logic                     with_tail;
  logic signed [ACCW-1:0]   final_d;

  assign in_ready = (state_q == ST_LOAD);
  assign accept   = in_valid && in_ready;
  assign seg_full = accept && (wr_idx_q == AW'(SEG_LEN - 1));
  assign tap_last = (state_q == ST_CONV) && (k_q == KW'(TAPS - 1));
  assign emit     = tap_last && (n_q <  NW'(SEG_LEN));
  assign tail_wr  = tap_last && (n_q >= NW'(SEG_LEN));
  assign seg_done = tap_last && (n_q == NW'(LAST_N));

  // Sample position n-k inside the current segment, if any.
  assign diff_u = {1'b0, n_q} - (NW + 1)'(k_q);
  assign in_seg = ({1'b0, n_q} >= (NW + 1)'(k_q)) && (diff_u < (NW + 1)'(SEG_LEN));
  assign x_eff  = in_seg ? x_rd : '0;

  ola_sample_buf #(.DW(DATA_W), .DEPTH(SEG_LEN)) u_buf (
    .clk   (clk),
    .we    (accept),
    .waddr (wr_idx_q),
    .wdata (in_data),
    .raddr (diff_u[AW-1:0]),
    .rdata (x_rd)
  );

  ola_coef_bank #(.CW(COEF_W), .TAPS(TAPS)) u_coef (
    .clk   (clk),
    .rst   (rst),
    .we    (coef_we),
    .waddr (coef_addr),
    .wdata (coef_data),
    .raddr (k_q),
    .rdata (h_rd)
  );

  ola_mac #(.DW(DATA_W), .CW(COEF_W), .ACCW(ACCW)) u_mac (
    .clk     (clk),
    .rst     (rst),
    .step    (state_q == ST_CONV),
    .restart (tap_last),
    .x       (x_eff),
    .h       (h_rd),
    .acc_q   (acc_q),
    .sum_d   (sum_d)
  );

  ola_tail_store #(.ACCW(ACCW), .DEPTH(TDEPTH)) u_tail (
    .clk   (clk),
    .rst   (rst),
    .we    (tail_wr),
    .waddr (TAW'(n_q - NW'(SEG_LEN))),
    .wdata (sum_d),
    .raddr (TAW'(n_q)),
    .rdata (tail_rd)
  );

  assign with_tail = (n_q < NW'(TDEPTH));
  assign final_d   = sum_d + (with_tail ? tail_rd : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_LOAD;
      wr_idx_q  <= '0;
      n_q       <= '0;
      k_q       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= emit;
      if (emit) out_data <= clip(final_d);
      unique case (state_q)
        ST_LOAD: begin
          if (accept) begin
            wr_idx_q <= seg_full ? '0 : wr_idx_q + AW'(1);
            if (seg_full) begin
              state_q <= ST_CONV;
              n_q     <= '0;
              k_q     <= '0;
            end
          end
        end
        ST_CONV: begin
          if (tap_last) begin
            k_q <= '0;
            if (seg_done) begin
              state_q <= ST_LOAD;
              n_q     <= '0;
            end else begin
              n_q <= n_q + NW'(1);
            end
          end else begin
            k_q <= k_q + KW'(1);
          end
        end
        default: state_q <= ST_LOAD;
      endcase
    end
  end

endmodule

// File: rtl/ola_fir_chk.sv
module ola_fir_chk #(
  parameter int N = 64
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic seg_full,
  input logic tail_wr
);

  localparam int CW = $clog2(N) + 2;

  logic [CW-1:0] in_cnt;
  logic [CW-1:0] out_cnt;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cnt  <= '0;
      out_cnt <= '0;
      seen    <= 1'b0;
    end else begin
      if (seg_full) begin
        in_cnt  <= '0;
        out_cnt <= '0;
        seen    <= 1'b1;
      end else begin
        if (in_valid && in_ready) in_cnt <= in_cnt + CW'(1);
        if (out_valid)            out_cnt <= out_cnt + CW'(1);
      end
    end
  end

  // R1: a segment closes on exactly its N-th accepted sample
  a_r1_seg_size: assert property (@(posedge clk) disable iff (rst)
    seg_full |-> in_cnt == CW'(N - 1));

  // R2: outputs never overlap with the gathering phase
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && in_ready));

  // R2: the previous segment delivered exactly N outputs
  a_r2_out_count: assert property (@(posedge clk) disable iff (rst)
    (seg_full && seen) |-> out_cnt == CW'(N));

  // R4: tail values are only stored once all outputs of the segment are out
  a_r4_tail_after_out: assert property (@(posedge clk) disable iff (rst)
    tail_wr |-> out_cnt == CW'(N));

  // R8: reset silences the output
  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

bind ola_fir_top ola_fir_chk #(.N(SEG_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .seg_full  (seg_full),
  .tail_wr   (tail_wr)
);

// File: tb/ola_fir_top_tb.sv
module ola_fir_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 8;
  localparam int M    = 4;
  localparam int DW   = 8;
  localparam int CW   = 8;
  localparam int OW   = 12;
  localparam int KW   = $clog2(M);
  localparam int OMAX = (1 << (OW - 1)) - 1;
  localparam int OMIN = -(1 << (OW - 1));
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [DW-1:0] in_data = '0;
  logic coef_we = 1'b0;
  logic [KW-1:0] coef_addr = '0;
  logic signed [CW-1:0] coef_data = '0;
  logic out_valid;
  logic signed [OW-1:0] out_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int out_idx = 0;
  int cur_len = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;
  string ph_tag = "R3";

  int xs [64];
  int hk [M];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ola_fir_top #(.SEG_LEN(N), .TAPS(M), .DATA_W(DW), .COEF_W(CW), .OUT_W(OW)) u_dut (
    .clk, .rst, .in_valid, .in_ready, .in_data,
    .coef_we, .coef_addr, .coef_data, .out_valid, .out_data
  );

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Direct convolution of the whole stream, then clipping.
  function automatic int ref_raw(input int idx);
    int s = 0;
    for (int k = 0; k < M; k++)
      if (idx - k >= 0) s += xs[idx - k] * hk[k];
    return s;
  endfunction

  function automatic int ref_clip(input int v);
    if (v > OMAX) return OMAX;
    if (v < OMIN) return OMIN;
    return v;
  endfunction

  // Output monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (mon_en && out_valid) begin
      if (out_idx >= cur_len) begin
        check(1'b0, "R2", out_idx, cur_len - 1, "extra output");
      end else begin
        int raw;
        int ex;
        string tg;
        raw = ref_raw(out_idx);
        ex  = ref_clip(raw);
        if (out_idx < M - 1)          tg = "R5";
        else if (out_idx % N < M - 1) tg = "R4";
        else if (raw != ex)           tg = "R6";
        else                          tg = ph_tag;
        check(int'(out_data) == ex, tg, int'(out_data), ex, $sformatf("sample %0d", out_idx));
      end
      out_idx++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    // R8: after a reset cycle the block is idle and ready
    check(out_valid == 1'b0, "R8", int'(out_valid), 0, "out_valid after reset");
    check(in_ready == 1'b1, "R8", int'(in_ready), 1, "in_ready after reset");
    rst = 1'b0;
  endtask

  task automatic load_coefs();
    for (int k = 0; k < M; k++) begin
      @(negedge clk);
      coef_we   = 1'b1;
      coef_addr = KW'(k);
      coef_data = CW'(hk[k]);
    end
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic run_phase(input int len, input string tag);
    int i = 0;
    bit just_filled = 1'b0;
    do_reset();
    load_coefs();
    ph_tag  = tag;
    cur_len = len;
    out_idx = 0;
    mon_en  = 1'b1;
    while (i < len) begin
      @(negedge clk);
      if (just_filled) begin
        // R1: a full segment stops further intake
        check(in_ready == 1'b0, "R1", int'(in_ready), 0, "in_ready after segment filled");
        just_filled = 1'b0;
      end
      in_valid = 1'b1;
      if (in_ready) begin
        in_data = DW'(xs[i]);
        i++;
        if (i % N == 0) just_filled = 1'b1;
      end else begin
        in_data = DW'(99); // R9: junk offered while busy must not be taken
      end
    end
    @(negedge clk);
    if (just_filled)
      check(in_ready == 1'b0, "R1", int'(in_ready), 0, "in_ready after last segment filled");
    in_valid = 1'b0;
    for (int w = 0; w < 4000 && out_idx < len; w++) @(negedge clk);
    repeat (N * M) @(negedge clk);
    check(out_idx == len, "R2", out_idx, len, "output count");
    // R9: nothing was taken while busy, so N-1 more samples leave the block gathering
    for (int j = 0; j < N - 1; j++) begin
      in_valid = 1'b1;
      in_data  = '0;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(in_ready == 1'b1, "R9", int'(in_ready), 1, "still gathering after N-1 extra samples");
    mon_en = 1'b0;
  endtask

  initial begin
    // R7: impulse exposes tap order, response straddles a segment boundary
    hk = '{4, -3, 2, 1};
    for (int i = 0; i < 16; i++) xs[i] = 0;
    xs[6]  = 5;
    xs[13] = -7;
    run_phase(16, "R7");

    // R3: mixed pattern over four segments
    hk = '{3, -5, 7, -2};
    for (int i = 0; i < 32; i++) xs[i] = ((i * 37) % 41) - 20;
    run_phase(32, "R3");

    // R6: full-scale values force clipping both ways
    hk = '{127, 127, -128, 127};
    for (int i = 0; i < 24; i++) xs[i] = ((i / 3) % 2 == 1) ? -128 : 127;
    xs[20] = 1; xs[21] = 0; xs[22] = -1; xs[23] = 2;
    run_phase(24, "R6");

    // R5: previous phase left a nonzero tail; reset must clear it
    hk = '{-1, 2, -3, 4};
    for (int i = 0; i < 24; i++) xs[i] = i - 12;
    run_phase(24, "R3");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule